// File: doc/BRIEF.md
# SAR Capacitor Calibration Sequencer

This block measures, stores and applies a digital correction code for each of the upper capacitors of a successive-approximation converter's binary-weighted array. A calibration run walks through these capacitors one at a time. For each one it asks the converter core for a fixed, power-of-two number of signed error measurements through a request/acknowledge handshake. It adds them into a wide signed accumulator and reduces the sum to an average with an arithmetic right shift. The average is clamped to the width of the correction code and kept in a shadow register.

When every capacitor has been measured, the shadow codes are copied into the live codes in a single step. The live codes drive one correction output per capacitor. During conversions each output carries its capacitor's live code only while that capacitor's main-DAC data bit is 1, and zero otherwise. A run starts by itself when reset is released and again whenever the user requests one while the block is idle. The converter core holds off conversions while the busy flag is high. A full run spans thousands of clocks.

Top module: `sar_cal_sequencer`

## Requirements
- R1: Reset clears every live code to zero, so all correction outputs read zero, and clears cal_done. A run starts automatically: cal_busy and meas_req are 1 from the first cycle after reset is released.
- R2: A measurement is transferred on a rising clock edge where meas_req and meas_ack are both 1. With meas_ack low the sequencer waits indefinitely, and meas_req and meas_idx stay unchanged.
- R3: Capacitors are measured in ascending meas_idx order, 0 to NUM_MSB-1, where index 0 is the smallest capacitor of the calibrated group. Each index receives exactly 2^REPS_LOG2 transfers before meas_idx advances by one.
- R4: A capacitor's code is the sum of its error samples divided by 2^REPS_LOG2 and rounded toward minus infinity (arithmetic shift). The sum is held without overflow.
- R5: An average above 2^(CODE_W-1)-1 is stored as 2^(CODE_W-1)-1. An average below -2^(CODE_W-1) is stored as -2^(CODE_W-1).
- R6: corr_code bits [i*CODE_W +: CODE_W] carry capacitor i's live code, in two's complement, when dac_bits[i] is 1, and all zeros when dac_bits[i] is 0.
- R7: The live codes change only at the completion of a run. During a run the outputs keep the codes of the last completed run. A reset during a run leaves all codes at zero.
- R8: At the edge that completes a run, cal_busy falls and cal_done rises. cal_done then stays 1 until the next run starts.
- R9: A cal_start pulse while idle starts a run: from the next cycle cal_busy is 1 and cal_done is 0. A cal_start pulse while cal_busy is 1 is ignored and does not cause an extra run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | User calibration request |
| meas_req | output | 1 | Sequencer wants an error measurement |
| meas_idx | output | IDX_W | Capacitor under measurement |
| meas_ack | input | 1 | Core presents a measurement this cycle |
| meas_err | input | ERR_W | Signed error sample |
| dac_bits | input | NUM_MSB | Main-DAC data bits of the calibrated capacitors |
| corr_code | output | NUM_MSB*CODE_W | Gated correction codes, one field per capacitor |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Last run completed |

## Verification
The bench builds the block with three calibrated capacitors, 10-bit error samples, 6-bit codes and eight repetitions per capacitor. A full run therefore lasts only a few dozen cycles, so many runs and a reset in mid-run fit easily. Because the code range is much narrower than the error range, averages of large samples of either sign reach the clamps, which exercises both saturation limits. With eight samples, sums that are not multiples of eight appear, and negative ones among them expose the rounding direction.

// File: rtl/sar_cal_pkg.sv
package sar_cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_MEAS   = 2'd1,
    CAL_COMMIT = 2'd2
  } cal_state_t;
endpackage

// File: rtl/sar_cal_accum.sv
module sar_cal_accum #(
  parameter int ERR_W     = 12,
  parameter int REPS_LOG2 = 6,
  parameter int CODE_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     take,
  input  logic signed [ERR_W-1:0]  err,
  output logic                     last,
  output logic signed [CODE_W-1:0] avg_code
);
  localparam int ACC_W  = ERR_W + REPS_LOG2;
  localparam int CNT_W  = (REPS_LOG2 > 0) ? REPS_LOG2 : 1;
  localparam int CMAX_I = 2**(CODE_W-1) - 1;
  localparam int CMIN_I = -(2**(CODE_W-1));

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_sum;
  logic [CNT_W-1:0]        cnt_q;

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [ERR_W-1:0] e);
    return ACC_W'(e);
  endfunction

  function automatic logic signed [CODE_W-1:0] shift_and_clamp(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] q;
    q = s >>> REPS_LOG2;
    if (q > $signed(ACC_W'(CMAX_I)))      return CODE_W'(CMAX_I);
    else if (q < $signed(ACC_W'(CMIN_I))) return CODE_W'(CMIN_I);
    else                                  return q[CODE_W-1:0];
  endfunction

  assign acc_sum  = acc_q + widen(err);
  assign last     = take && (cnt_q == CNT_W'((2**REPS_LOG2) - 1));
  assign avg_code = shift_and_clamp(acc_sum);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_sum;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (acc_q[ACC_W-1] == err[ERR_W-1])) |-> (acc_sum[ACC_W-1] == acc_q[ACC_W-1])); // R4
endmodule

// File: rtl/sar_cal_store.sv
module sar_cal_store #(
  parameter int NUM_MSB = 4,
  parameter int CODE_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic signed [CODE_W-1:0]    wr_code,
  input  logic                        commit,
  output logic [NUM_MSB*CODE_W-1:0]   live_flat
);
  logic [NUM_MSB*CODE_W-1:0] shadow_flat;

  for (genvar gi = 0; gi < NUM_MSB; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_flat[gi*CODE_W +: CODE_W] <= '0;
        live_flat[gi*CODE_W +: CODE_W]   <= '0;
      end else begin
        if (wr_en && (wr_idx == IDX_W'(gi)))
          shadow_flat[gi*CODE_W +: CODE_W] <= wr_code;
        if (commit)
          live_flat[gi*CODE_W +: CODE_W] <= shadow_flat[gi*CODE_W +: CODE_W];
      end
    end
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_flat)); // R7
endmodule

// File: rtl/sar_cal_gate.sv
module sar_cal_gate #(
  parameter int NUM_MSB = 4,
  parameter int CODE_W  = 8
) (
  input  logic [NUM_MSB-1:0]        bits,
  input  logic [NUM_MSB*CODE_W-1:0] codes,
  output logic [NUM_MSB*CODE_W-1:0] gated
);
  for (genvar gi = 0; gi < NUM_MSB; gi++) begin : g_lane
    assign gated[gi*CODE_W +: CODE_W] = bits[gi] ? codes[gi*CODE_W +: CODE_W] : '0;
  end
endmodule

// File: rtl/sar_cal_sequencer.sv
module sar_cal_sequencer #(
  parameter int NUM_MSB   = 4,
  parameter int ERR_W     = 12,
  parameter int CODE_W    = 8,
  parameter int REPS_LOG2 = 6,
  localparam int IDX_W    = (NUM_MSB > 1) ? $clog2(NUM_MSB) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cal_start,
  output logic                      meas_req,
  output logic [IDX_W-1:0]          meas_idx,
  input  logic                      meas_ack,
  input  logic signed [ERR_W-1:0]   meas_err,
  input  logic [NUM_MSB-1:0]        dac_bits,
  output logic [NUM_MSB*CODE_W-1:0] corr_code,
  output logic                      cal_busy,
  output logic                      cal_done
);
  import sar_cal_pkg::*;

  cal_state_t               state_q;
  logic [IDX_W-1:0]         idx_q;
  logic                     done_q;
  logic                     take_w;
  logic                     cap_last_w;
  logic                     start_fire_w;
  logic                     commit_w;
  logic                     final_cap_w;
  logic signed [CODE_W-1:0] avg_w;
  logic [NUM_MSB*CODE_W-1:0] live_w;

  assign take_w       = (state_q == CAL_MEAS) && meas_ack;
  assign start_fire_w = (state_q == CAL_IDLE) && cal_start;
  assign commit_w     = (state_q == CAL_COMMIT);
  assign final_cap_w  = (idx_q == IDX_W'(NUM_MSB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAL_MEAS;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        CAL_IDLE: if (cal_start) begin
          state_q <= CAL_MEAS;
          idx_q   <= '0;
          done_q  <= 1'b0;
        end
        CAL_MEAS: if (cap_last_w) begin
          if (final_cap_w) state_q <= CAL_COMMIT;
          else             idx_q   <= idx_q + 1'b1;
        end
        CAL_COMMIT: begin
          state_q <= CAL_IDLE;
          idx_q   <= '0;
          done_q  <= 1'b1;
        end
        default: state_q <= CAL_IDLE;
      endcase
    end
  end

  sar_cal_accum #(.ERR_W(ERR_W), .REPS_LOG2(REPS_LOG2), .CODE_W(CODE_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(start_fire_w), .take(take_w),
    .err(meas_err), .last(cap_last_w), .avg_code(avg_w)
  );

  sar_cal_store #(.NUM_MSB(NUM_MSB), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_last_w), .wr_idx(idx_q),
    .wr_code(avg_w), .commit(commit_w), .live_flat(live_w)
  );

  sar_cal_gate #(.NUM_MSB(NUM_MSB), .CODE_W(CODE_W)) u_gate (
    .bits(dac_bits), .codes(live_w), .gated(corr_code)
  );

  assign meas_req = (state_q == CAL_MEAS);
  assign meas_idx = idx_q;
  assign cal_busy = (state_q != CAL_IDLE);
  assign cal_done = done_q;

  AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> (meas_idx < IDX_W'(NUM_MSB))); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && $past(meas_req) && (meas_idx != $past(meas_idx)))
      |-> (meas_idx == $past(meas_idx) + 1'b1)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !meas_ack) |=> (meas_req && $stable(meas_idx))); // R2
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> cal_busy); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> !cal_busy); // R8
  AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(commit_w)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && meas_req) |=> cal_busy); // R9
endmodule

// File: tb/sar_cal_sequencer_tb.sv
module sar_cal_sequencer_tb_top;
  localparam int NM = 3;
  localparam int EW = 10;
  localparam int CW = 6;
  localparam int RL = 3;
  localparam int REPS = 2**RL;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic meas_req;
  logic [IW-1:0] meas_idx;
  logic meas_ack = 1'b0;
  logic signed [EW-1:0] meas_err = '0;
  logic [NM-1:0] dac_bits = '1;
  logic [NM*CW-1:0] corr_code;
  logic cal_busy, cal_done;

  always #10ns clk = ~clk;

  sar_cal_sequencer #(.NUM_MSB(NM), .ERR_W(EW), .CODE_W(CW), .REPS_LOG2(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .meas_req(meas_req),
    .meas_idx(meas_idx), .meas_ack(meas_ack), .meas_err(meas_err),
    .dac_bits(dac_bits), .corr_code(corr_code), .cal_busy(cal_busy), .cal_done(cal_done)
  );

  int n_chk = 0, n_bad = 0;
  int mode = 0;
  bit stall = 1'b0;
  int cyc = 0;
  int exp_q[$];
  int exp_live[NM];
  int sums[NM];
  int reps[NM];
  int last_idx = -1;
  bit prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int err_of(input int m, input int cap, input int k);
    case (m)
      0: return 5*cap + (k % 3) - 1;
      1: return ((k % 2) != 0) ? -37 - cap : 22 + 3*cap;
      2: return 400 + cap;
      default: return -450 - k;
    endcase
  endfunction

  function automatic int model_code(input int s);
    int q;
    q = s / REPS;
    if (s < 0 && (s % REPS) != 0) q = q - 1;
    if (q > 2**(CW-1) - 1) q = 2**(CW-1) - 1;
    if (q < -(2**(CW-1))) q = -(2**(CW-1));
    return q;
  endfunction

  function automatic int lane(input int i);
    logic signed [CW-1:0] v;
    v = corr_code[i*CW +: CW];
    return int'(v);
  endfunction

  // driver: answers measurement requests and pushes expected codes
  always @(negedge clk) begin
    cyc++;
    if (!rst_n || !cal_busy) begin
      for (int i = 0; i < NM; i++) begin sums[i] = 0; reps[i] = 0; end
      last_idx = -1;
      meas_ack <= 1'b0;
    end else if (meas_req) begin
      bit a;
      int ix;
      int v;
      a = stall ? ((cyc % 3) != 0) : 1'b1;
      ix = int'(meas_idx);
      meas_ack <= a;
      if (a) begin
        if (ix != last_idx) begin
          chk(ix == last_idx + 1, "R3 order", ix, last_idx + 1);
          last_idx = ix;
        end
        v = err_of(mode, ix, reps[ix]);
        meas_err <= EW'(v);
        sums[ix] += v;
        reps[ix]++;
        if (reps[ix] == REPS) exp_q.push_back(model_code(sums[ix]));
      end
    end else begin
      meas_ack <= 1'b0;
    end
  end

  // monitor: on completion pop expected codes and compare all lanes
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) exp_live[i] = 0;
      exp_q.delete();
    end else if (cal_done && !prev_done) begin
      chk(!cal_busy, "R8 busy low at done", cal_busy, 0);
      chk(exp_q.size() == NM, "R3 caps completed", exp_q.size(), NM);
      for (int i = 0; i < NM; i++) begin
        if (exp_q.size() > 0) exp_live[i] = exp_q.pop_front();
        chk(lane(i) == exp_live[i], "R4/R5 stored code", lane(i), exp_live[i]);
      end
    end
    prev_done = cal_done;
  end

  task automatic wait_done();
    int t;
    t = 0;
    while (!cal_done && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    if (t >= 2000) chk(1'b0, "R8 run timeout", t, 0);
  endtask

  task automatic start_run(input int m, input bit st);
    mode = m;
    stall = st;
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk(cal_busy == 1'b1, "R9 busy after start", cal_busy, 1);
    chk(cal_done == 1'b0, "R9 done cleared", cal_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cal_busy == 1'b1, "R1 auto busy", cal_busy, 1);
    chk(meas_req == 1'b1, "R1 auto req", meas_req, 1);
    chk(cal_done == 1'b0, "R1 done low", cal_done, 0);
    chk(corr_code == '0, "R1 codes zero", int'(corr_code), 0);
    wait_done();

    // R6 gating patterns
    dac_bits = 3'b010;
    #1;
    chk(lane(0) == 0 && lane(2) == 0, "R6 gated off", lane(0) + lane(2), 0);
    chk(lane(1) == exp_live[1], "R6 gated on", lane(1), exp_live[1]);
    dac_bits = 3'b101;
    #1;
    chk(lane(1) == 0, "R6 gated off", lane(1), 0);
    chk(lane(2) == exp_live[2], "R6 gated on", lane(2), exp_live[2]);
    dac_bits = '1;

    // R2 stalls, R7 old codes held during run, R9 start ignored while busy
    start_run(1, 1'b1);
    repeat (10) @(negedge clk);
    for (int i = 0; i < NM; i++)
      chk(lane(i) == exp_live[i], "R7 old code held", lane(i), exp_live[i]);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);
    chk(cal_busy == 1'b0, "R9 no extra run", cal_busy, 0);
    chk(cal_done == 1'b1, "R8 done held", cal_done, 1);

    // R5 saturation both ways
    start_run(2, 1'b0);
    wait_done();
    chk(lane(0) == 31, "R5 positive clamp", lane(0), 31);
    start_run(3, 1'b1);
    wait_done();
    chk(lane(2) == -32, "R5 negative clamp", lane(2), -32);

    // R7 reset during run
    start_run(0, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(corr_code == '0, "R7 reset clears codes", int'(corr_code), 0);
    chk(cal_busy == 1'b1, "R1 auto rerun", cal_busy, 1);
    wait_done();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3ms;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule